// File: doc/BRIEF.md
# Ping-Pong Gather DMA Engine

This engine moves data from external memory into a local scratchpad through two alternating landing buffers. While a consumer works on one buffer, the engine fills the other. A buffer that has been filled stays reserved until the consumer hands it back. Memory is addressed in 16-byte words. Each request fetches one word, and responses return in request order.

The engine has two command modes. In stream mode it copies a run of equally sized chunks from consecutive external words, one chunk per buffer fill, and alternates between the buffers. In list mode it walks a table of descriptors that software has placed in the scratchpad. Each descriptor names a scattered external region, and the engine packs those regions back to back into one buffer, in table order. The data then sits in the order the consumer will read it. Up to 32 word requests may be in flight before any response returns.

Top module: `pingpong_list_dma`

## Requirements
- R1: After reset, `busy`=0, `cmdReady`=1, `bufReady`=00, `errSize`=0, and no memory request is raised.
- R2: A stream command with size S bytes and count N copies N chunks of S/16 words, taken from consecutive external word addresses starting at `cmdExtAddr`. Each chunk lands contiguously from the base of a buffer (buffer 0 at local word 0, buffer 1 at local word 1024). The fills alternate between the buffers, and the first fill after reset goes to buffer 0. The matching `bufReady` bit is set once the chunk's last word is written.
- R3: The engine never writes into a buffer whose `bufReady` bit is set. If the next buffer is still reserved, the engine waits without issuing requests until that buffer is released.
- R4: A `bufReady` bit stays set until a one-cycle pulse on the matching `bufRelease` bit clears it. A release pulse for a buffer that is not ready changes nothing.
- R5: A valid transfer size is a multiple of 16 bytes from 16 to 16384. Any other stream size, or any count above 2048, rejects the command: `errSize` is set, `busy` stays 0, and no request is issued. A count of 0 is accepted and does nothing. Each accepted command clears `errSize`.
- R6: A list command reads `cmdCount` descriptor words, one per word, starting at local word `cmdListBase`. Bits [31:0] of a descriptor hold the external word address and bits [46:32] hold the size in bytes. The engine gathers every described region back to back into the next buffer in descriptor order, then sets that buffer's `bufReady` bit.
- R7: A descriptor with an invalid size sets `errSize` and is skipped without any request. The descriptors after it are still processed.
- R8: At most 32 requests are outstanding. With slow responses, the engine keeps issuing until exactly 32 are outstanding.
- R9: A raised request keeps `memReqValid` high and `memReqAddr` unchanged until `memReqReady` accepts it.
- R10: Commands are accepted only while `cmdReady` is 1. `cmdReady` is 0 whenever `busy` is 1, and a command offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command taken |
| cmdList | input | 1 | 1 = list mode, 0 = stream mode |
| cmdExtAddr | input | 32 | Stream start external word address |
| cmdSize | input | 15 | Stream chunk size in bytes |
| cmdCount | input | 12 | Chunks (stream) or descriptors (list) |
| cmdListBase | input | 12 | Local word address of the first descriptor |
| memReqValid | output | 1 | Word read request |
| memReqReady | input | 1 | Request accepted |
| memReqAddr | output | 32 | External word address |
| memRspValid | input | 1 | Response word present |
| memRspData | input | 128 | Response word |
| lmWrEn | output | 1 | Scratchpad write |
| lmWrAddr | output | 12 | Scratchpad write word address |
| lmWrData | output | 128 | Scratchpad write data |
| lmRdEn | output | 1 | Scratchpad descriptor read |
| lmRdAddr | output | 12 | Descriptor word address |
| lmRdData | input | 128 | Descriptor word, one cycle after `lmRdEn` |
| bufReady | output | 2 | Per-buffer filled flag |
| bufRelease | input | 2 | Per-buffer release pulse |
| busy | output | 1 | Command in progress |
| errSize | output | 1 | Bad size or count seen |

## Verification
Several properties are checked on every cycle by assertions: a ready buffer is never written, a ready flag holds until it is released, the outstanding count never passes the limit, a stalled request holds its address, and a bad stream size is rejected at once. Some behaviour can only be shown by the scenarios. These include the landing order of gathered words, the alternation of buffers across commands, the wait for a release, the skipping of bad descriptors, and the outstanding count actually reaching its limit under slow memory.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAITBUF, S_FETCH, S_ENTRY, S_ISSUE, S_DRAIN
  } pldState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;    // capture command addresses
    logic startFill;  // point write pointer at a buffer base
    logic fillBuf;    // which buffer startFill selects
    logic loadEntry;  // take descriptor address, advance list pointer
    logic skipEntry;  // advance list pointer only
    logic issueBeat;  // request accepted, advance external address
  } pldStrobe_t;
endpackage

// File: rtl/pld_dpath.sv
module pld_dpath
  import pld_pkg::*;
#(
  parameter int EAW       = 32,
  parameter int LAW       = 12,
  parameter int DW        = 128,
  parameter int SIZE_W    = 15,
  parameter int BUF0_BASE = 0,
  parameter int BUF1_BASE = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  pldStrobe_t        strb,
  input  logic [EAW-1:0]    cmdExtAddr,
  input  logic [LAW-1:0]    cmdListBase,
  input  logic [DW-1:0]     lmRdData,
  input  logic              memRspValid,
  input  logic [DW-1:0]     memRspData,
  output logic [EAW-1:0]    memReqAddr,
  output logic [LAW-1:0]    lmRdAddr,
  output logic              lmWrEn,
  output logic [LAW-1:0]    lmWrAddr,
  output logic [DW-1:0]     lmWrData,
  output logic [SIZE_W-1:0] entrySize
);
  localparam logic [LAW-1:0] BASE0 = LAW'(BUF0_BASE);
  localparam logic [LAW-1:0] BASE1 = LAW'(BUF1_BASE);

  logic [EAW-1:0] extAddr;
  logic [LAW-1:0] listPtr;
  logic [LAW-1:0] wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extAddr <= '0;
      listPtr <= '0;
      wrPtr   <= '0;
    end else begin
      if (strb.loadCmd) begin
        extAddr <= cmdExtAddr;
        listPtr <= cmdListBase;
      end else if (strb.loadEntry) begin
        extAddr <= lmRdData[EAW-1:0];
        listPtr <= listPtr + 1'b1;
      end else begin
        if (strb.skipEntry) listPtr <= listPtr + 1'b1;
        if (strb.issueBeat) extAddr <= extAddr + 1'b1;
      end
      if (strb.startFill) wrPtr <= strb.fillBuf ? BASE1 : BASE0;
      else if (memRspValid) wrPtr <= wrPtr + 1'b1;
    end
  end

  assign memReqAddr = extAddr;
  assign lmRdAddr   = listPtr;
  assign lmWrEn     = memRspValid;
  assign lmWrAddr   = wrPtr;
  assign lmWrData   = memRspData;
  assign entrySize  = lmRdData[EAW +: SIZE_W];
endmodule

// File: rtl/pld_ctrl.sv
module pld_ctrl
  import pld_pkg::*;
#(
  parameter int SIZE_W    = 15,
  parameter int CNT_W     = 12,
  parameter int MAX_BYTES = 16384,
  parameter int MAX_ITEMS = 2048,
  parameter int MAX_OUT   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdList,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [SIZE_W-1:0] entrySize,
  input  logic [1:0]        bufRelease,
  output logic              cmdReady,
  output logic              busy,
  output logic              memReqValid,
  output logic              lmRdEn,
  output logic [1:0]        bufReady,
  output logic              errSize,
  output pldStrobe_t        strb
);
  localparam int OUT_W  = $clog2(MAX_OUT + 1);
  localparam int BEAT_W = SIZE_W - 4;
  localparam logic [SIZE_W-1:0] MAX_BYTES_V = SIZE_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0]  MAX_ITEMS_V = CNT_W'(MAX_ITEMS);
  localparam logic [OUT_W-1:0]  MAX_OUT_V   = OUT_W'(MAX_OUT);

  pldState_e         state;
  logic              curBuf, listMode;
  logic [BEAT_W-1:0] beatsLeft, beatsPer;
  logic [CNT_W-1:0]  itemsLeft;
  logic [OUT_W-1:0]  outCnt;
  logic              fire, entryOk, fillDone;

  function automatic logic sizeOk(input logic [SIZE_W-1:0] s);
    return (s != '0) && (s[3:0] == 4'd0) && (s <= MAX_BYTES_V);
  endfunction

  always_comb begin
    strb           = '0;
    strb.loadCmd   = (state == S_IDLE) && cmdValid;
    strb.fillBuf   = curBuf;
    strb.startFill = (state == S_WAITBUF) && !bufReady[curBuf];
    entryOk        = sizeOk(entrySize);
    strb.loadEntry = (state == S_ENTRY) && entryOk;
    strb.skipEntry = (state == S_ENTRY) && !entryOk;
    memReqValid    = (state == S_ISSUE) && (outCnt < MAX_OUT_V);
    fire           = memReqValid && memReqReady;
    strb.issueBeat = fire;
    lmRdEn         = (state == S_FETCH);
    fillDone       = (state == S_DRAIN) && (outCnt == '0);
  end

  assign busy     = (state != S_IDLE);
  assign cmdReady = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curBuf    <= 1'b0;
      listMode  <= 1'b0;
      beatsLeft <= '0;
      beatsPer  <= '0;
      itemsLeft <= '0;
      outCnt    <= '0;
      bufReady  <= '0;
      errSize   <= 1'b0;
    end else begin
      outCnt   <= outCnt + OUT_W'(fire) - OUT_W'(memRspValid);
      bufReady <= (bufReady & ~bufRelease)
                | (fillDone ? (curBuf ? 2'b10 : 2'b01) : 2'b00);
      unique case (state)
        S_IDLE: if (cmdValid) begin
          errSize   <= 1'b0;
          listMode  <= cmdList;
          itemsLeft <= cmdCount;
          beatsPer  <= cmdSize[SIZE_W-1:4];
          if (cmdCount == '0) state <= S_IDLE;
          else if (cmdCount > MAX_ITEMS_V) errSize <= 1'b1;
          else if (!cmdList && !sizeOk(cmdSize)) errSize <= 1'b1;
          else state <= S_WAITBUF;
        end
        S_WAITBUF: if (!bufReady[curBuf]) begin
          beatsLeft <= beatsPer;
          state     <= listMode ? S_FETCH : S_ISSUE;
        end
        S_FETCH: state <= S_ENTRY;
        S_ENTRY: begin
          itemsLeft <= itemsLeft - 1'b1;
          if (entryOk) begin
            beatsLeft <= entrySize[SIZE_W-1:4];
            state     <= S_ISSUE;
          end else begin
            errSize <= 1'b1;
            state   <= (itemsLeft == CNT_W'(1)) ? S_DRAIN : S_FETCH;
          end
        end
        S_ISSUE: if (fire) begin
          beatsLeft <= beatsLeft - 1'b1;
          if (beatsLeft == BEAT_W'(1))
            state <= (listMode && itemsLeft != '0) ? S_FETCH : S_DRAIN;
        end
        S_DRAIN: if (outCnt == '0) begin
          curBuf <= ~curBuf;
          if (listMode) state <= S_IDLE;
          else begin
            itemsLeft <= itemsLeft - 1'b1;
            state     <= (itemsLeft == CNT_W'(1)) ? S_IDLE : S_WAITBUF;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_list_dma.sv
module pingpong_list_dma
  import pld_pkg::*;
#(
  parameter int EAW       = 32,
  parameter int LAW       = 12,
  parameter int DW        = 128,
  parameter int MAX_BYTES = 16384,
  parameter int MAX_ITEMS = 2048,
  parameter int MAX_OUT   = 32,
  parameter int BUF0_BASE = 0,
  parameter int BUF1_BASE = 1024,
  localparam int SIZE_W   = $clog2(MAX_BYTES) + 1,
  localparam int CNT_W    = $clog2(MAX_ITEMS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdList,
  input  logic [EAW-1:0]    cmdExtAddr,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [LAW-1:0]    cmdListBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [EAW-1:0]    memReqAddr,
  input  logic              memRspValid,
  input  logic [DW-1:0]     memRspData,
  output logic              lmWrEn,
  output logic [LAW-1:0]    lmWrAddr,
  output logic [DW-1:0]     lmWrData,
  output logic              lmRdEn,
  output logic [LAW-1:0]    lmRdAddr,
  input  logic [DW-1:0]     lmRdData,
  output logic [1:0]        bufReady,
  input  logic [1:0]        bufRelease,
  output logic              busy,
  output logic              errSize
);
  pldStrobe_t        strb;
  logic [SIZE_W-1:0] entrySize;

  pld_ctrl #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES),
    .MAX_ITEMS(MAX_ITEMS), .MAX_OUT(MAX_OUT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdList(cmdList),
    .cmdSize(cmdSize), .cmdCount(cmdCount), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .entrySize(entrySize), .bufRelease(bufRelease),
    .cmdReady(cmdReady), .busy(busy), .memReqValid(memReqValid),
    .lmRdEn(lmRdEn), .bufReady(bufReady), .errSize(errSize), .strb(strb)
  );

  pld_dpath #(
    .EAW(EAW), .LAW(LAW), .DW(DW), .SIZE_W(SIZE_W),
    .BUF0_BASE(BUF0_BASE), .BUF1_BASE(BUF1_BASE)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdExtAddr(cmdExtAddr),
    .cmdListBase(cmdListBase), .lmRdData(lmRdData), .memRspValid(memRspValid),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .lmRdAddr(lmRdAddr),
    .lmWrEn(lmWrEn), .lmWrAddr(lmWrAddr), .lmWrData(lmWrData),
    .entrySize(entrySize)
  );
endmodule

// File: rtl/pld_chk.sv
module pld_chk #(
  parameter int LAW       = 12,
  parameter int SIZE_W    = 15,
  parameter int CNT_W     = 12,
  parameter int MAX_BYTES = 16384,
  parameter int MAX_OUT   = 32,
  parameter int BUF0_BASE = 0,
  parameter int BUF1_BASE = 1024
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              cmdList,
  input logic [SIZE_W-1:0] cmdSize,
  input logic [CNT_W-1:0]  cmdCount,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [31:0]       memReqAddr,
  input logic              memRspValid,
  input logic              lmWrEn,
  input logic [LAW-1:0]    lmWrAddr,
  input logic [1:0]        bufReady,
  input logic [1:0]        bufRelease,
  input logic              busy,
  input logic              errSize
);
  localparam int BEATS = MAX_BYTES / 16;
  int chkOut;

  always_ff @(posedge clk) begin
    if (!rstN) chkOut <= 0;
    else chkOut <= chkOut + int'(memReqValid && memReqReady) - int'(memRspValid);
  end

  logic inBuf0, inBuf1;
  assign inBuf0 = int'(lmWrAddr) >= BUF0_BASE && int'(lmWrAddr) < BUF0_BASE + BEATS;
  assign inBuf1 = int'(lmWrAddr) >= BUF1_BASE && int'(lmWrAddr) < BUF1_BASE + BEATS;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkOut <= MAX_OUT);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  // R4
  ready0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufReady[0] && !bufRelease[0] |=> bufReady[0]);
  // R4
  ready1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufReady[1] && !bufRelease[1] |=> bufReady[1]);
  // R3
  no_overwrite0_chk: assert property (@(posedge clk) disable iff (!rstN)
    lmWrEn && inBuf0 |-> !bufReady[0]);
  // R3
  no_overwrite1_chk: assert property (@(posedge clk) disable iff (!rstN)
    lmWrEn && inBuf1 |-> !bufReady[1]);
  // R5
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && !cmdList && cmdCount != '0 && cmdSize[3:0] != 4'd0
    |=> errSize && !busy);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && chkOut == 0);
endmodule

bind pingpong_list_dma pld_chk #(
  .LAW(LAW), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES),
  .MAX_OUT(MAX_OUT), .BUF0_BASE(BUF0_BASE), .BUF1_BASE(BUF1_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdList(cmdList), .cmdSize(cmdSize), .cmdCount(cmdCount),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr), .memRspValid(memRspValid), .lmWrEn(lmWrEn),
  .lmWrAddr(lmWrAddr), .bufReady(bufReady), .bufRelease(bufRelease),
  .busy(busy), .errSize(errSize)
);

// File: tb/pingpong_list_dma_tb_top.sv
module pingpong_list_dma_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rstN;
  logic         cmdValid, cmdReady, cmdList;
  logic [31:0]  cmdExtAddr;
  logic [14:0]  cmdSize;
  logic [11:0]  cmdCount;
  logic [11:0]  cmdListBase;
  logic         memReqValid, memReqReady;
  logic [31:0]  memReqAddr;
  logic         memRspValid;
  logic [127:0] memRspData;
  logic         lmWrEn, lmRdEn;
  logic [11:0]  lmWrAddr, lmRdAddr;
  logic [127:0] lmWrData, lmRdData;
  logic [1:0]   bufReady, bufRelease;
  logic         busy, errSize;

  pingpong_list_dma dut_i (.*);

  int nChecks = 0, nErr = 0;
  int reqCount = 0, maxOut = 0, lat = 2, cyc = 0;
  logic readyRandom = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] qa[$];
  int qt[$];
  logic [127:0] lm [0:4095];
  logic tbNext = 1'b0;

  function automatic logic [127:0] memVal(input logic [31:0] a);
    return {a ^ 32'h5A5A0000, ~a, a + 32'h1111, a};
  endfunction

  // scratchpad model
  always @(posedge clk) begin
    if (lmWrEn) lm[lmWrAddr] <= lmWrData;
    if (lmRdEn) lmRdData <= lm[lmRdAddr];
  end

  // external memory model, in-order responses after lat cycles
  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReqReady <= readyRandom ? lfsr[3] : 1'b1;
    if (!rstN) begin
      qa.delete(); qt.delete();
      memRspValid <= 1'b0;
    end else begin
      if (memRspValid) begin
        void'(qa.pop_front()); void'(qt.pop_front());
      end
      if (memReqValid && memReqReady) begin
        qa.push_back(memReqAddr); qt.push_back(cyc);
        reqCount++;
        if (qa.size() > maxOut) maxOut = qa.size();
      end
      if (qa.size() > 0 && qt[0] + lat <= cyc) begin
        memRspValid <= 1'b1;
        memRspData  <= memVal(qa[0]);
      end else memRspValid <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic sendCmd(input logic lst, input logic [31:0] ext, input logic [14:0] sz,
                         input logic [11:0] cnt, input logic [11:0] lbase);
    @(negedge clk);
    cmdValid = 1'b1; cmdList = lst; cmdExtAddr = ext;
    cmdSize = sz; cmdCount = cnt; cmdListBase = lbase;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
  endtask

  task automatic releaseBuf(input logic [1:0] m);
    @(negedge clk); bufRelease = m;
    @(negedge clk); bufRelease = 2'b00;
  endtask

  function automatic int nextBase();
    return tbNext ? 1024 : 0;
  endfunction

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 cmdReady", cmdReady, 1);
    chk("R1 bufReady", bufReady, 0);
    chk("R1 errSize", errSize, 0);
    chk("R1 memReqValid", memReqValid, 0);
  endtask

  task automatic t_stream();
    int b0, r0;
    r0 = reqCount;
    b0 = nextBase();
    sendCmd(0, 100, 64, 2, 0);
    waitIdle();
    for (int i = 0; i < 4; i++) chk("R2 chunk0 data", lm[b0 + i], memVal(100 + i));
    for (int i = 0; i < 4; i++) chk("R2 chunk1 data", lm[(b0 ^ 1024) + i], memVal(104 + i));
    chk("R2 both ready", bufReady, 2'b11);
    chk("R2 request count", reqCount - r0, 8);
  endtask

  task automatic t_block();
    int r0, b;
    b = nextBase();
    r0 = reqCount;
    sendCmd(0, 200, 32, 1, 0);
    repeat (40) @(negedge clk);
    chk("R3 waits busy", busy, 1);
    chk("R3 no requests while blocked", reqCount - r0, 0);
    chk("R3 buffer untouched", lm[b], memVal(100));
    chk("R4 ready held", bufReady, 2'b11);
    releaseBuf(b == 0 ? 2'b01 : 2'b10);
    waitIdle();
    chk("R3 refill data", lm[b + 1], memVal(201));
    chk("R3 refill stops at size", lm[b + 2], memVal(102));
    chk("R3 ready again", bufReady, 2'b11);
    tbNext = ~tbNext;
  endtask

  task automatic t_badsize();
    int r0;
    r0 = reqCount;
    releaseBuf(2'b11);
    releaseBuf(2'b11);
    chk("R4 release of free buffer ignored", bufReady, 2'b00);
    sendCmd(0, 0, 24, 1, 0);
    chk("R5 size 24 flagged", {errSize, busy}, 2'b10);
    sendCmd(0, 0, 0, 1, 0);
    chk("R5 size 0 flagged", {errSize, busy}, 2'b10);
    sendCmd(0, 0, 16400, 1, 0);
    chk("R5 size 16400 flagged", {errSize, busy}, 2'b10);
    sendCmd(0, 0, 16, 2049, 0);
    chk("R5 count 2049 flagged", {errSize, busy}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R5 no requests issued", reqCount - r0, 0);
  endtask

  task automatic t_bounds();
    int b, bad;
    b = nextBase();
    lat = 80; maxOut = 0;
    sendCmd(0, 3000, 16384, 1, 0);
    chk("R5 accepted clears error", errSize, 0);
    waitIdle();
    bad = 0;
    for (int i = 0; i < 1024; i++) if (lm[b + i] !== memVal(3000 + i)) bad++;
    chk("R5 16384-byte chunk mismatches", bad, 0);
    chk("R8 outstanding peak", maxOut, 32);
    tbNext = ~tbNext;
    lat = 2;
    b = nextBase();
    sendCmd(0, 77, 16, 1, 0);
    waitIdle();
    chk("R5 16-byte chunk", lm[b], memVal(77));
    chk("R5 16-byte chunk ready", bufReady, 2'b11);
    tbNext = ~tbNext;
  endtask

  task automatic t_list();
    int b;
    releaseBuf(2'b11);
    b = nextBase();
    @(negedge clk);
    lm[2048] = {81'd0, 15'd32, 32'd500};
    lm[2049] = {81'd0, 15'd20, 32'd9};
    lm[2050] = {81'd0, 15'd16, 32'd7};
    lm[2051] = {81'd0, 15'd48, 32'd300};
    sendCmd(1, 0, 0, 4, 2048);
    waitIdle();
    chk("R6 gather 0", lm[b + 0], memVal(500));
    chk("R6 gather 1", lm[b + 1], memVal(501));
    chk("R7 skipped entry, next lands", lm[b + 2], memVal(7));
    chk("R6 gather 3", lm[b + 3], memVal(300));
    chk("R6 gather 5", lm[b + 5], memVal(302));
    chk("R7 error flagged", errSize, 1);
    chk("R6 buffer ready", bufReady[tbNext], 1);
    tbNext = ~tbNext;
  endtask

  task automatic t_throttle();
    int b0;
    releaseBuf(2'b11);
    b0 = nextBase();
    readyRandom = 1'b1; lat = 3;
    sendCmd(0, 4000, 48, 2, 0);
    waitIdle();
    readyRandom = 1'b0;
    for (int i = 0; i < 3; i++) chk("R9 throttled chunk0", lm[b0 + i], memVal(4000 + i));
    for (int i = 0; i < 3; i++) chk("R9 throttled chunk1", lm[(b0 ^ 1024) + i], memVal(4003 + i));
    lat = 2;
  endtask

  task automatic t_busyCmd();
    int r0, b;
    b = nextBase();
    r0 = reqCount;
    sendCmd(0, 900, 16, 1, 0);
    chk("R10 cmdReady low while busy", cmdReady, 0);
    sendCmd(0, 950, 16, 1, 0);
    releaseBuf(b == 0 ? 2'b01 : 2'b10);
    waitIdle();
    repeat (20) @(negedge clk);
    chk("R10 extra command ignored", reqCount - r0, 1);
    chk("R10 data from first command", lm[b], memVal(900));
    chk("R10 idle", busy, 0);
    tbNext = ~tbNext;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdList = 1'b0; cmdExtAddr = '0;
    cmdSize = '0; cmdCount = '0; cmdListBase = '0; bufRelease = 2'b00;
    for (int i = 0; i < 4096; i++) lm[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_block();
    t_badsize();
    t_bounds();
    t_list();
    t_throttle();
    t_busyCmd();
    finishRun();
  end
endmodule